// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a memory-mapped interval timer. A 32-bit up-counter advances on ticks taken from one of three strobe inputs: a bus-clock strobe, a peripheral-clock strobe, or an oscillator strobe. The oscillator path has its own small divider. The two ordinary sources share a wider general divider. Software programs a compare value. When the counter reaches that value, a sticky status flag is set. If its mask bit allows, a registered level interrupt follows.

A control bit chooses the behaviour after a match. In free-run mode the counter keeps counting through the match and wraps. In restart mode it returns to zero on the tick after the match. A wait-mode input pauses counting unless the control register permits running while waiting. Counting is governed by a three-state sequencer. OFF means the module is disabled. RUN means ticks are counted. HOLD means wait mode is active and not permitted. Its transitions are: OFF to RUN on enable; RUN to HOLD when wait is asserted without permission; HOLD to RUN when that condition ends; RUN or HOLD to OFF when the enable bit is cleared.

Top module: `cmp_timer`

## Requirements
- R1: After reset, control, prescaler, status, interrupt-enable and counter read 0, compare reads 0xFFFFFFFF, and `irq` is low.
- R2: While control bit 0 (enable) is clear, the counter does not move and no status event occurs. Any write of the control register (offset 0x00) with bit 0 clear sets the counter and both divider states to 0.
- R3: Control field [8:6] selects the source: 1 takes `stb_bus`, 2 takes `stb_per`, and both pass through the general divider in prescaler bits [11:0], where value N gives one tick per N+1 strobes. Any code other than 1, 2 or 5 produces no ticks, and an unselected strobe has no effect.
- R4: Source code 5 takes `stb_osc` only while control bit 10 is set. It passes through the oscillator divider in prescaler bits [15:12] (N gives /N+1) and ignores the general divider.
- R5: With control bit 9 set (free-run), the counter increments by one on every tick, including the tick after a match.
- R6: With control bit 9 clear (restart), the tick that follows a count equal to the compare value loads 0.
- R7: Status bit 0 (offset 0x08) is set on the tick that makes the counter equal to the compare value (offset 0x10). Writing 1 to it clears it, and writing 0 leaves it as it is. A match in the same cycle as a clear wins.
- R8: `irq` is a register equal to status bit 0 AND interrupt-enable bit 0 (offset 0x0C), one cycle behind them. Masking it does not clear the status.
- R9: While `wait_mode` is high and control bit 3 is clear, counting pauses. With bit 3 set, counting continues during wait.
- R10: A compare value that the counter has already passed produces no match until the counter comes back around to it.
- R11: Writes are stored only in implemented bits (control mask 0x7C9, prescaler mask 0xFFFF). The counter at offset 0x24 is read-only, and writing it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| stb_bus | input | 1 | Bus-clock tick strobe |
| stb_per | input | 1 | Peripheral-clock tick strobe |
| stb_osc | input | 1 | Oscillator tick strobe |
| wait_mode | input | 1 | Low-power wait indication |
| irq | output | 1 | Level interrupt |

## Verification
A vector table drives each source code with different strobe combinations. An unselected strobe held high shows whether the selection is applied. Divider values of 0, 1, 3 and 7 on each path show whether the right field is used and whether it is off by one. Runs that stop exactly on a match, and one tick after it, tell restart mode apart from free-run and show whether the match is flagged at the right count. Directed sequences then cover the W1C write-zero case, masking, wait pause against wait permission, a compare value already passed, disable-clear, and write masking.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int GPRE_W = 12;
    localparam int OPRE_W = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PRE  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_CMP  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h24;

    localparam int B_EN    = 0;
    localparam int B_WAITE = 3;
    localparam int B_SRC_L = 6;
    localparam int B_FRR   = 9;
    localparam int B_OSCE  = 10;
    localparam int B_OPRE_L = 12;

    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_07C9;
    localparam logic [DATA_W-1:0] PRE_MASK  = 32'h0000_FFFF;

    localparam logic [2:0] SRC_BUS = 3'd1;
    localparam logic [2:0] SRC_PER = 3'd2;
    localparam logic [2:0] SRC_OSC = 3'd5;

    typedef enum logic [1:0] {
        CORE_OFF  = 2'd0,
        CORE_RUN  = 2'd1,
        CORE_HOLD = 2'd2
    } core_state_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         adv_i,
    input  logic         stb_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);
    logic [W-1:0] pcnt_q;
    logic         hit;

    assign hit    = (pcnt_q >= div_i);
    assign tick_o = adv_i & stb_i & hit;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            pcnt_q <= '0;
        end else if (adv_i && stb_i) begin
            pcnt_q <= hit ? '0 : pcnt_q + 1'b1;
        end
    end

    // R2: a disable write leaves the divider at zero
    a_r2_div_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pcnt_q == '0));
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              adv_i,
    input  logic [2:0]        src_i,
    input  logic              osc_en_i,
    input  logic [GPRE_W-1:0] gdiv_i,
    input  logic [OPRE_W-1:0] odiv_i,
    input  logic              stb_bus_i,
    input  logic              stb_per_i,
    input  logic              stb_osc_i,
    output logic              tick_o
);
    logic gen_stb, osc_stb, gen_tick, osc_tick;

    always_comb begin
        unique case (src_i)
            SRC_BUS: gen_stb = stb_bus_i;
            SRC_PER: gen_stb = stb_per_i;
            default: gen_stb = 1'b0;
        endcase
    end

    assign osc_stb = (src_i == SRC_OSC) && osc_en_i && stb_osc_i;

    tmr_prescaler #(.W(GPRE_W)) u_gen_div (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .adv_i(adv_i),
        .stb_i(gen_stb), .div_i(gdiv_i), .tick_o(gen_tick)
    );

    tmr_prescaler #(.W(OPRE_W)) u_osc_div (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .adv_i(adv_i),
        .stb_i(osc_stb), .div_i(odiv_i), .tick_o(osc_tick)
    );

    assign tick_o = gen_tick | osc_tick;

    // R4: oscillator source without its enable never ticks
    a_r4_osc_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == SRC_OSC && !osc_en_i) |-> !tick_o);
    // R3: no ticks without advance permission
    a_r3_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |-> !tick_o);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              wait_en_i,
    input  logic              wait_i,
    input  logic              frr_i,
    input  logic              clr_i,
    input  logic              tick_i,
    input  logic [DATA_W-1:0] cmp_i,
    output logic              run_o,
    output logic              match_o,
    output logic [DATA_W-1:0] cnt_o
);
    core_state_e state_q, state_d;
    logic [DATA_W-1:0] cnt_q, cnt_nxt;
    logic step;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CORE_OFF:  if (en_i) state_d = CORE_RUN;
            CORE_RUN:  if (!en_i) state_d = CORE_OFF;
                       else if (wait_i && !wait_en_i) state_d = CORE_HOLD;
            CORE_HOLD: if (!en_i) state_d = CORE_OFF;
                       else if (!(wait_i && !wait_en_i)) state_d = CORE_RUN;
            default:   state_d = CORE_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CORE_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        run_o = (state_q == CORE_RUN);
    end

    assign step    = tick_i && run_o && !clr_i;
    assign cnt_nxt = (!frr_i && cnt_q == cmp_i) ? '0 : cnt_q + 1'b1;
    assign match_o = step && (cnt_nxt == cmp_i);
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_q <= '0;
        else if (step)       cnt_q <= cnt_nxt;
    end

    // R2: outside RUN the counter stays put unless cleared
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CORE_RUN && !clr_i) |=> $stable(cnt_q));
    // R5: free-run increments on every counted tick
    a_r5_freerun: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && state_q == CORE_RUN && frr_i && !clr_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R6: restart mode reloads zero after a match count
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && state_q == CORE_RUN && !frr_i && cnt_q == cmp_i && !clr_i) |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              match_i,
    input  logic [DATA_W-1:0] cnt_i,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0] pre_o,
    output logic [DATA_W-1:0] cmp_o,
    output logic              clr_o,
    output logic              irq_o
);
    logic [DATA_W-1:0] ctrl_q, pre_q, cmp_q;
    logic stat_q, ien_q, irq_q;
    logic wr_ctrl, wr_pre, wr_stat, wr_ien, wr_cmp;

    assign wr_ctrl = wr_i && (addr_i == OFS_CTRL);
    assign wr_pre  = wr_i && (addr_i == OFS_PRE);
    assign wr_stat = wr_i && (addr_i == OFS_STAT);
    assign wr_ien  = wr_i && (addr_i == OFS_IEN);
    assign wr_cmp  = wr_i && (addr_i == OFS_CMP);
    assign clr_o   = wr_ctrl && !wdata_i[B_EN];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            pre_q  <= '0;
            cmp_q  <= '1;
            ien_q  <= 1'b0;
            stat_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata_i & CTRL_MASK;
            if (wr_pre)  pre_q  <= wdata_i & PRE_MASK;
            if (wr_cmp)  cmp_q  <= wdata_i;
            if (wr_ien)  ien_q  <= wdata_i[0];
            if (match_i)                    stat_q <= 1'b1;
            else if (wr_stat && wdata_i[0]) stat_q <= 1'b0;
            irq_q <= stat_q & ien_q;
        end
    end

    always_comb begin
        unique case (addr_i)
            OFS_CTRL: rdata_o = ctrl_q;
            OFS_PRE:  rdata_o = pre_q;
            OFS_STAT: rdata_o = {{(DATA_W-1){1'b0}}, stat_q};
            OFS_IEN:  rdata_o = {{(DATA_W-1){1'b0}}, ien_q};
            OFS_CMP:  rdata_o = cmp_q;
            OFS_CNT:  rdata_o = cnt_i;
            default:  rdata_o = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign pre_o  = pre_q;
    assign cmp_o  = cmp_q;
    assign irq_o  = irq_q;

    // R7: a match always leaves the flag set
    a_r7_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        match_i |=> stat_q);
    // R8: interrupt follows flag and mask one cycle later
    a_r8_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_q == ($past(stat_q) && $past(ien_q))));
    // R7: without a write of one and without a match the flag never falls
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !(wr_stat && wdata_i[0])) |=> stat_q);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              stb_bus,
    input  logic              stb_per,
    input  logic              stb_osc,
    input  logic              wait_mode,
    output logic              irq
);
    logic [DATA_W-1:0] ctrl, pre, cmp, cnt;
    logic clr, match, run, tick;

    tmr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .rdata_o(bus_rdata), .match_i(match),
        .cnt_i(cnt), .ctrl_o(ctrl), .pre_o(pre), .cmp_o(cmp),
        .clr_o(clr), .irq_o(irq)
    );

    tmr_tick_gen u_ticks (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .adv_i(run),
        .src_i(ctrl[B_SRC_L +: 3]), .osc_en_i(ctrl[B_OSCE]),
        .gdiv_i(pre[GPRE_W-1:0]), .odiv_i(pre[B_OPRE_L +: OPRE_W]),
        .stb_bus_i(stb_bus), .stb_per_i(stb_per), .stb_osc_i(stb_osc),
        .tick_o(tick)
    );

    tmr_core u_core (
        .clk(clk), .rst_n(rst_n), .en_i(ctrl[B_EN]), .wait_en_i(ctrl[B_WAITE]),
        .wait_i(wait_mode), .frr_i(ctrl[B_FRR]), .clr_i(clr), .tick_i(tick),
        .cmp_i(cmp), .run_o(run), .match_o(match), .cnt_o(cnt)
    );
endmodule

// File: tb/cmp_timer_tb_top.sv
module cmp_timer_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic stb_bus = 1'b0, stb_per = 1'b0, stb_osc = 1'b0, wait_mode = 1'b0;
    logic irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cmp_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stb_bus(stb_bus),
        .stb_per(stb_per), .stb_osc(stb_osc), .wait_mode(wait_mode), .irq(irq)
    );

    // vector fields: source code, osc enable, prescaler, compare, free-run,
    // strobe mask {osc,per,bus}, strobe cycles, expected count, expected flag
    localparam int NV = 7;
    localparam int V_SRC [NV] = '{1, 1, 2, 5, 5, 3, 1};
    localparam int V_OSE [NV] = '{0, 0, 0, 1, 0, 0, 0};
    localparam int V_PRE [NV] = '{0, 3, 1, 32'h7005, 0, 0, 0};
    localparam int V_CMP [NV] = '{100, 5, 3, 32'hFFFF, 1, 1, 4};
    localparam int V_FRR [NV] = '{1, 1, 0, 1, 1, 1, 0};
    localparam int V_MSK [NV] = '{1, 1, 6, 5, 4, 7, 1};
    localparam int V_N   [NV] = '{10, 20, 18, 40, 40, 10, 5};
    localparam int V_CNT [NV] = '{10, 5, 1, 5, 0, 0, 0};
    localparam int V_ST  [NV] = '{0, 1, 1, 0, 0, 0, 1};

    function automatic string vtag(int i);
        case (i)
            0: return "R3/R5 bus div1";
            1: return "R3/R7 bus div4";
            2: return "R3/R6 per div2 restart";
            3: return "R4 osc div8";
            4: return "R4 osc disabled";
            5: return "R3 invalid source";
            default: return "R6 restart edge";
        endcase
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input int msk, input int n);
        @(negedge clk);
        stb_bus = msk[0]; stb_per = msk[1]; stb_osc = msk[2];
        repeat (n) @(negedge clk);
        stb_bus = 1'b0; stb_per = 1'b0; stb_osc = 1'b0;
        idle(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1 reset values
        rd(8'h00, v); chk("R1 ctrl", v, 0);
        rd(8'h04, v); chk("R1 pre", v, 0);
        rd(8'h08, v); chk("R1 status", v, 0);
        rd(8'h0C, v); chk("R1 ien", v, 0);
        rd(8'h10, v); chk("R1 compare", v, 32'hFFFF_FFFF);
        rd(8'h24, v); chk("R1 counter", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        for (int i = 0; i < NV; i++) begin
            wr(8'h00, 0);
            wr(8'h08, 1);
            wr(8'h04, V_PRE[i]);
            wr(8'h10, V_CMP[i]);
            wr(8'h00, 1 | (V_SRC[i] << 6) | (V_FRR[i] << 9) | (V_OSE[i] << 10));
            idle(2);
            strobe(V_MSK[i], V_N[i]);
            rd(8'h24, v); chk({vtag(i), " count"}, v, V_CNT[i]);
            rd(8'h08, v); chk({vtag(i), " flag"}, v, V_ST[i]);
        end

        // R8 flag is set from last vector; unmask then mask
        wr(8'h0C, 1);
        idle(1);
        chk("R8 irq asserted", {31'b0, irq}, 1);
        wr(8'h0C, 0);
        idle(1);
        chk("R8 irq masked", {31'b0, irq}, 0);
        rd(8'h08, v); chk("R8 flag kept when masked", v, 1);
        // R7 write-one-to-clear
        wr(8'h08, 0);
        rd(8'h08, v); chk("R7 write zero keeps flag", v, 1);
        wr(8'h08, 1);
        rd(8'h08, v); chk("R7 write one clears flag", v, 0);

        // R9 wait mode
        wr(8'h00, 0);
        wr(8'h04, 0);
        wr(8'h10, 1000);
        wait_mode = 1'b1;
        wr(8'h00, 32'h241);
        idle(2);
        strobe(1, 10);
        rd(8'h24, v); chk("R9 paused in wait", v, 0);
        wr(8'h00, 32'h249);
        idle(2);
        strobe(1, 6);
        rd(8'h24, v); chk("R9 runs with wait permission", v, 6);
        wait_mode = 1'b0;

        // R10 compare already passed
        wr(8'h10, 3);
        strobe(1, 10);
        rd(8'h24, v); chk("R10 count past compare", v, 16);
        rd(8'h08, v); chk("R10 no match", v, 0);

        // R2 disable clears and holds
        wr(8'h10, 0);
        wr(8'h00, 32'h240);
        rd(8'h24, v); chk("R2 disable clears", v, 0);
        strobe(7, 5);
        rd(8'h24, v); chk("R2 holds while off", v, 0);
        rd(8'h08, v); chk("R2 no event while off", v, 0);

        // R11 masking and read-only counter
        wr(8'h24, 32'h55);
        rd(8'h24, v); chk("R11 counter read-only", v, 0);
        wr(8'h00, 32'hFFFF_FFFE);
        rd(8'h00, v); chk("R11 ctrl mask", v, 32'h7C8);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R11 prescaler mask", v, 32'hFFFF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule